// File: doc/BRIEF.md
# Three-Signal Bus Ownership Controller

This block sits beside the cycle sequencer of a local bus master that shares its bus with other masters. An outside master raises a request. The controller answers with a grant pulse once the local side is between bus cycles. It then waits for the outside master to acknowledge that it has taken the bus. While the bus is away, the controller turns off the local output drivers, except for the arbitration signals, which always stay driven.

Ownership comes back only after both the request and the acknowledge have dropped. One idle clock is then spent before the local drivers turn on again. Arbitration is settled at every cycle boundary, so a two-part local operation can lose the bus between its halves.

A permission output tells the sequencer when it may start a new strobe. A hold output flags that the sequencer has work waiting while ownership is elsewhere. If a request is already asserted when reset ends, the bus is handed over before any local cycle starts.

Top module: `bus_owner_ctl`

## Requirements
- R1: In reset and on the first clock after it, with no request or acknowledge present, `bus_grant` is 0, `drive_en` is 1 and `cycle_ok` is 1.
- R2: Suppose `bus_req` is 1 and `strobe_busy` is 0 at a rising edge while the block owns the bus. Then `bus_grant` is 1 and `drive_en` is 0 after that edge.
- R3: While `strobe_busy` is 1, a request produces no grant. The grant appears after the first edge at which `strobe_busy` is sampled 0.
- R4: When `bus_ack` is 1 at an edge while `bus_grant` is 1, `bus_grant` is 0 after that edge.
- R5: After the bus has been handed over, `drive_en` and `cycle_ok` stay 0 for as long as `bus_req` or `bus_ack` is 1.
- R6: After the first edge at which both `bus_req` and `bus_ack` are sampled 0 while released, one clock follows with `drive_en` still 0. After the next edge, `drive_en` and `cycle_ok` are 1.
- R7: `cycle_ok` is 0 in the same cycle whenever `bus_req` or `bus_ack` is 1.
- R8: `local_hold` is 1 exactly when `local_want` is 1 and `cycle_ok` is 0.
- R9: If `bus_req` is 1 when reset is released, `cycle_ok` stays 0 and `bus_grant` is 1 after the first edge.
- R10: If `bus_req` drops while granting with no acknowledge, the block goes through the same one-clock turnaround as R6 and then owns the bus again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Request from an outside master, active high |
| bus_ack | input | 1 | Outside master confirms it holds the bus, active high |
| strobe_busy | input | 1 | Local address strobe currently active |
| local_want | input | 1 | Local sequencer has a cycle waiting |
| bus_grant | output | 1 | Grant to the outside master |
| drive_en | output | 1 | Enable for local bus output drivers |
| cycle_ok | output | 1 | Local sequencer may start a strobe |
| local_hold | output | 1 | Local cycle waiting while ownership is away |

## Verification
Two events can fall in the same cycle: an outside request and an active local strobe. The bench holds `strobe_busy` high across the clock where `bus_req` rises, keeps it high for several edges, then drops it. It judges the outcome by checking that no grant appears until the edge after the strobe ends.

A second overlap happens at reset release, where a pending request meets the sequencer's first chance to start a cycle. The bench checks that the permission stays low and that the grant appears first.

// File: rtl/bus_owner_ctl.sv
module bus_owner_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req,
  input  logic bus_ack,
  input  logic strobe_busy,
  input  logic local_want,
  output logic bus_grant,
  output logic drive_en,
  output logic cycle_ok,
  output logic local_hold
);

  typedef enum logic [1:0] {OWNED, GRANTING, RELEASED, RECLAIM} own_t;
  own_t st, st_nxt;

  always_comb begin
    st_nxt = st;
    case (st)
      OWNED:    if (bus_req && !strobe_busy) st_nxt = GRANTING;
      GRANTING: if (bus_ack) st_nxt = RELEASED;
                else if (!bus_req) st_nxt = RECLAIM;
      RELEASED: if (!bus_req && !bus_ack) st_nxt = RECLAIM;
      default:  st_nxt = OWNED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= OWNED;
    else        st <= st_nxt;

  assign bus_grant  = (st == GRANTING);
  assign drive_en   = (st == OWNED);
  assign cycle_ok   = (st == OWNED) && !bus_req && !bus_ack;
  assign local_hold = local_want && !cycle_ok;

  p_grant_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_grant) |-> !$past(strobe_busy));

  p_ack_drops_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && bus_ack) |=> !bus_grant);

  p_stay_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RELEASED && (bus_req || bus_ack)) |=> (!drive_en && !cycle_ok));

  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> (!$past(drive_en) && !$past(bus_req, 2) && !$past(bus_ack, 2)));

  p_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req || bus_ack) |-> !cycle_ok);

endmodule

// File: tb/tb_bus_owner_ctl.sv
module tb_bus_owner_ctl;
  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_ack = 0, strobe_busy = 0, local_want = 0;
  logic bus_grant, drive_en, cycle_ok, local_hold;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_owner_ctl dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic t_reset();
    rst_n = 0; local_want = 1; #1;
    chk("R1 grant in reset", bus_grant, 0);
    chk("R1 drive in reset", drive_en, 1);
    step(); rst_n = 1; step();
    chk("R1 grant after reset", bus_grant, 0);
    chk("R1 drive after reset", drive_en, 1);
    chk("R1 cycle_ok after reset", cycle_ok, 1);
    chk("R8 no hold when allowed", local_hold, 0);
    local_want = 0;
  endtask

  task automatic t_idle_handover();
    local_want = 1; bus_req = 1; #1;
    chk("R7 cycle_ok drops with req", cycle_ok, 0);
    chk("R8 hold while req", local_hold, 1);
    step();
    chk("R2 grant after req", bus_grant, 1);
    chk("R2 drive off", drive_en, 0);
    bus_ack = 1; step();
    chk("R4 grant drops on ack", bus_grant, 0);
    bus_req = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R5 drive off while ack", drive_en, 0);
      chk("R5 cycle_ok off while ack", cycle_ok, 0);
    end
    bus_ack = 0; step();
    chk("R6 turnaround drive off", drive_en, 0);
    chk("R6 turnaround cycle_ok off", cycle_ok, 0);
    step();
    chk("R6 drive back", drive_en, 1);
    chk("R6 cycle_ok back", cycle_ok, 1);
    chk("R8 hold clears", local_hold, 0);
    local_want = 0;
  endtask

  task automatic t_busy_overlap();
    strobe_busy = 1; bus_req = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R3 no grant mid-strobe", bus_grant, 0);
      chk("R3 drive kept mid-strobe", drive_en, 1);
    end
    strobe_busy = 0; step();
    chk("R3 grant after strobe ends", bus_grant, 1);
    bus_ack = 1; step(); bus_req = 0; bus_ack = 0; step(); step();
    chk("R6 owned again", drive_en, 1);
  endtask

  task automatic t_withdraw();
    bus_req = 1; step();
    chk("R10 grant", bus_grant, 1);
    bus_req = 0; step();
    chk("R10 grant gone", bus_grant, 0);
    chk("R10 turnaround drive off", drive_en, 0);
    step();
    chk("R10 drive back", drive_en, 1);
    chk("R10 cycle_ok back", cycle_ok, 1);
  endtask

  task automatic t_pending_at_reset();
    rst_n = 0; bus_req = 1; local_want = 1; step();
    rst_n = 1; #1;
    chk("R9 no start at reset exit", cycle_ok, 0);
    chk("R9 hold at reset exit", local_hold, 1);
    step();
    chk("R9 grant first", bus_grant, 1);
    chk("R9 still no start", cycle_ok, 0);
    bus_ack = 1; step(); bus_req = 0; bus_ack = 0; step(); step();
    chk("R9 owned afterwards", cycle_ok, 1);
    local_want = 0;
  endtask

  initial begin
    t_reset();
    t_idle_handover();
    t_busy_overlap();
    t_withdraw();
    t_pending_at_reset();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule